// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between an internal single-access request port and an external byte-wide asynchronous static RAM. It has 19 address bits, an 8-bit bidirectional data bus, active-low chip select, output enable and write strobe, and an active-high second select. Each accepted request becomes a sequence of strobe phases. The length of each phase comes from a minimum time in nanoseconds divided by the clock period and rounded up, so every minimum of the memory is met or exceeded at any clock rate.

A write first selects the chip with the address and data already driven. It then holds the write strobe low long enough for pulse width, data setup and address-to-end time. It then raises the strobe while chip select, address and data stay put for a recovery stretch, so that the whole access covers the cycle time. A read lowers chip select and output enable together and keeps them low for the longest of address access, output-enable access and cycle time. It samples the bus on the last of those cycles. When no access is running, both selects are inactive and the data bus is released. A one-cycle acknowledge then marks completion, and read data stays registered until the next read.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Out of reset and whenever no access is running, chip select (active low) is 1, second select is 0, write strobe is 1, output enable is 1 and the acknowledge is 0.
- R2: In the first cycle of a write, chip select is 0 and the write strobe is still 1, with the address of the request already on the address pins.
- R3: The write strobe stays 0 for exactly WP_CYC consecutive cycles, the maximum of ceil(T_WP/CLK), ceil(T_DW/CLK) and ceil(T_AW/CLK)-1 (6 cycles at defaults).
- R4: Address and write data do not change while chip select is 0.
- R5: After the write strobe returns to 1, chip select stays 0 and the bus stays driven for REC_CYC cycles, the larger of 1 and ceil(T_WC/CLK)-1-WP_CYC (2 at defaults). Chip select is low for 1+WP_CYC+REC_CYC cycles per write.
- R6: A read holds chip select and output enable at 0, with the write strobe 1 and second select 1, for RD_CYC cycles, the maximum of ceil(T_AA/CLK), ceil(T_OE/CLK) and ceil(T_RC/CLK) (9 at defaults). The bus value on the last of those cycles becomes the read data.
- R7: The controller drives the data bus only during the three write phases, and never while output enable is 0.
- R8: The acknowledge is 1 for exactly one cycle, the cycle after the last cycle with chip select 0. Read data holds its value across writes until the next read completes.
- R9: A request is taken only when idle. Changes to the request fields while an access runs do not affect that access.
- R10: Chip select returns to 1 for at least one cycle between any two accesses, including back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Registered read data |
| mem_addr | output | 19 | Address to the memory |
| mem_dq | inout | 8 | Bidirectional memory data bus |
| mem_ce_n | output | 1 | Primary chip select, active low |
| mem_ce2 | output | 1 | Second chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The bench uses a timed memory model. It returns inverted data until 85 ns after output enable falls, so a read window one cycle short captures wrong bytes. It also counts write pulses under 60 ns, data set up less than 35 ns before the strobe rises, and address movement while both strobes are low. A controller that dropped the recovery stretch, or released the bus with the strobe, would store garbage that later reads expose. One access is run with the request held high and its fields changed mid-access: a controller that re-sampled them would write the wrong location or start a second access. Boundary addresses 0 and the top word, an overwrite, and read data holding across writes are all checked directly.

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl #(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int T_WP_NS = 60,
  parameter int T_DW_NS = 35,
  parameter int T_AW_NS = 70,
  parameter int T_WC_NS = 85,
  parameter int T_AA_NS = 85,
  parameter int T_OE_NS = 40,
  parameter int T_RC_NS = 85
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n
);
  localparam int C_WP = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_DW = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_AW = (T_AW_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_WC = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_AA = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_OE = (T_OE_NS + CLK_NS - 1) / CLK_NS;
  localparam int C_RC = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_A   = (C_WP > C_DW) ? C_WP : C_DW;
  localparam int WP_B   = (WP_A > C_AW - 1) ? WP_A : C_AW - 1;
  localparam int WP_CYC = (WP_B > 1) ? WP_B : 1;
  localparam int REC_CYC = (C_WC - 1 - WP_CYC > 1) ? C_WC - 1 - WP_CYC : 1;
  localparam int RD_A   = (C_AA > C_OE) ? C_AA : C_OE;
  localparam int RD_B   = (RD_A > C_RC) ? RD_A : C_RC;
  localparam int RD_CYC = (RD_B > 1) ? RD_B : 1;
  localparam int MAX_A  = (WP_CYC > REC_CYC) ? WP_CYC : REC_CYC;
  localparam int MAX_C  = (MAX_A > RD_CYC) ? MAX_A : RD_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_WSET, ST_WPUL, ST_WREC, ST_READ} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wd_q;
  logic              drv;
  logic              last;

  assign last     = (cnt == '0);
  assign drv      = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WREC);
  assign mem_ce_n = (state == ST_IDLE);
  assign mem_ce2  = (state != ST_IDLE);
  assign mem_we_n = (state != ST_WPUL);
  assign mem_oe_n = (state != ST_READ);
  assign mem_dq   = drv ? wd_q : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ack      <= 1'b0;
      mem_addr <= '0;
      wd_q     <= '0;
      rd_data  <= '0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: if (req) begin
          mem_addr <= req_addr;
          wd_q     <= req_wdata;
          state    <= req_we ? ST_WSET : ST_READ;
          cnt      <= req_we ? '0 : CNT_W'(RD_CYC - 1);
        end
        ST_WSET: begin
          state <= ST_WPUL;
          cnt   <= CNT_W'(WP_CYC - 1);
        end
        ST_WPUL: begin
          if (last) begin
            state <= ST_WREC;
            cnt   <= CNT_W'(REC_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WREC: begin
          if (last) begin
            state <= ST_IDLE;
            ack   <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        ST_READ: begin
          if (last) begin
            rd_data <= mem_dq;
            state   <= ST_IDLE;
            ack     <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else we_run <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_ce2));

  p_select_before_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_ce_n && $past(mem_ce_n) == 1'b0));

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= (CNT_W+1)'(WP_CYC)));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(mem_ce_n) == 1'b0) |-> $stable(mem_addr));

  p_read_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && mem_ce2 && !mem_ce_n));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> mem_oe_n);

  p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> mem_ce_n);
endmodule

// File: tb/sim_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_sram_strobe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WP_CYC  = 6;
  localparam int REC_CYC = 2;
  localparam int RD_CYC  = 9;
  localparam int WR_CE   = 1 + WP_CYC + REC_CYC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ack, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n;
  logic [7:0]  rd_data;
  logic [18:0] mem_addr;
  wire  [7:0]  mem_dq;

  int checks = 0, fails = 0, viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl #(.CLK_NS(CLK_PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n));

  // timed memory model
  bit [7:0] marr [int];
  logic [7:0] mout = 8'h00;
  realtime t_wfall = 0, t_dq = 0;
  assign mem_dq = (!mem_ce_n && mem_ce2 && !mem_oe_n && mem_we_n) ? mout : 8'bz;

  always @(mem_dq) t_dq = $realtime;
  always @(negedge mem_we_n) t_wfall = $realtime;
  always @(posedge mem_we_n) if (!mem_ce_n) begin
    if ($realtime - t_wfall < 60.0) viol++;
    if ($realtime - t_dq < 35.0) viol++;
    marr[int'(mem_addr)] = mem_dq;
  end
  always @(mem_addr) if (!mem_ce_n && !mem_we_n) viol++;
  always @(negedge mem_oe_n) begin
    mout = marr.exists(int'(mem_addr)) ? ~marr[int'(mem_addr)] : 8'hFF;
    #85;
    mout = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 8'h00;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_op(input bit we, input logic [18:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
    int lat, wl, cl;
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    lat = 1; wl = 0; cl = 0;
    if (we) chk(!mem_ce_n && mem_we_n && mem_addr == a, "R2", {mem_ce_n, mem_we_n}, 2'b01);
    else    chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_ce2, "R6", {mem_ce_n, mem_oe_n}, 2'b00);
    cl += int'(!mem_ce_n); wl += int'(!mem_we_n);
    while (!ack) begin
      @(negedge clk);
      lat++; cl += int'(!mem_ce_n); wl += int'(!mem_we_n);
    end
    chk(wl == (we ? WP_CYC : 0), "R3", wl, we ? WP_CYC : 0);
    chk(cl == (we ? WR_CE : RD_CYC), we ? "R5" : "R6", cl, we ? WR_CE : RD_CYC);
    chk(lat == cl + 1, "R8", lat, cl + 1);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R10", mem_ce_n, 1);
    rd = rd_data;
    @(negedge clk);
    chk(!ack, "R8", ack, 0);
  endtask

  localparam logic [35:0] VEC [12] = '{
    {1'b1, 19'h00000, 8'h3C, 8'h00},
    {1'b1, 19'h7FFFF, 8'hC3, 8'h00},
    {1'b1, 19'h12345, 8'hA5, 8'h00},
    {1'b1, 19'h54321, 8'h5A, 8'h00},
    {1'b0, 19'h00000, 8'h00, 8'h3C},
    {1'b0, 19'h7FFFF, 8'h00, 8'hC3},
    {1'b1, 19'h12345, 8'hFF, 8'h00},
    {1'b0, 19'h12345, 8'h00, 8'hFF},
    {1'b0, 19'h54321, 8'h00, 8'h5A},
    {1'b1, 19'h00001, 8'h00, 8'h00},
    {1'b0, 19'h00001, 8'h00, 8'h00},
    {1'b0, 19'h00000, 8'h00, 8'h3C}
  };

  bit [7:0] shadow [int];

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !ack, "R1",
        {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, ack}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !ack, "R1",
        {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, ack}, 5'b10110);

    foreach (VEC[i]) begin
      do_op(VEC[i][35], VEC[i][34:16], VEC[i][15:8], r);
      if (!VEC[i][35]) chk(r == VEC[i][7:0], "R6", r, VEC[i][7:0]);
    end

    // R8: read data holds across a write
    do_op(1'b0, 19'h7FFFF, 8'h00, r);
    do_op(1'b1, 19'h00100, 8'h77, r);
    chk(r == 8'hC3, "R8", r, 8'hC3);

    // R4/R5: random write then read-back
    for (int i = 0; i < 16; i++) begin
      int a = int'($urandom() & 32'h7FFFF);
      logic [7:0] d = 8'($urandom());
      shadow[a] = d;
      do_op(1'b1, 19'(a), d, r);
    end
    foreach (shadow[a]) begin
      do_op(1'b0, 19'(a), 8'h00, r);
      chk(r == shadow[a], "R4", r, shadow[a]);
    end

    // R9: request fields change while busy
    do_op(1'b1, 19'h0BEEF, 8'h11, r);
    @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 19'h0CAFE; req_wdata = 8'h22;
    @(negedge clk);
    req_addr = 19'h0BEEF; req_wdata = 8'h99; req_we = 1'b0;
    while (!ack) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(mem_ce_n, "R9", mem_ce_n, 1);
    do_op(1'b0, 19'h0BEEF, 8'h00, r);
    chk(r == 8'h11, "R9", r, 8'h11);
    do_op(1'b0, 19'h0CAFE, 8'h00, r);
    chk(r == 8'h22, "R9", r, 8'h22);

    chk(viol == 0, "R4", viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R8 actual=hung expected=ack");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule